// File: doc/BRIEF.md
# Slew-Limited DC Offset Remover

This block removes the DC component from a stream of signed samples. It keeps a running estimate of the DC level with extra fractional precision. Each valid sample moves the estimate toward that sample's value by exactly one fractional step, and the block outputs the sample minus the integer part of the estimate. The response is one minus a low-pass estimator, so a constant input is driven fully to zero once the estimate has caught up.

The step is 2^-F of an input LSB, with F a parameter. Each update is therefore a single compare followed by an increment or decrement, with no multiplier. Because the estimate moves at a fixed slew rate, it settles quickly once it is near the true level. A short burst of offset can pull it only a few steps.

The corrected sample comes out one cycle after its valid strobe, clamped to the signed output range. The current integer estimate is also presented as an output.

Top module: `dcTracker`

## Requirements
- R1: While the synchronous reset `rst` is high, the estimate is cleared to zero. After the first clock edge with reset high, `dcEstimate`, `outSample` and `outValid` all read zero.
- R2: `outValid` is high in exactly the cycle after a cycle with `inValid` high. There is one result for each accepted sample.
- R3: When a valid sample is greater than the integer estimate `dcEstimate`, the internal estimate grows by exactly one fractional unit, which is 2^-FRAC_W LSB. As a result, `dcEstimate` never rises by more than 1 per sample.
- R4: When a valid sample is less than `dcEstimate`, the internal estimate shrinks by exactly one fractional unit.
- R5: When a valid sample equals `dcEstimate`, the estimate, including its fractional bits, is left unchanged.
- R6: In a cycle without `inValid`, the estimate holds its value.
- R7: For each valid sample x, the result is x − E. Here E is the integer part (floor) of the estimate before that sample's update, read as two's complement. After the same edge, `dcEstimate` shows the updated estimate.
- R8: A difference above 2^(DATA_W−1)−1 is clamped to 2^(DATA_W−1)−1. It does not wrap.
- R9: A difference below −2^(DATA_W−1) is clamped to −2^(DATA_W−1).
- R10: Once a constant input has been applied long enough for the estimate to reach it, the result is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Sample strobe |
| inSample | input | DATA_W | Signed input sample |
| outValid | output | 1 | Result strobe, one cycle after `inValid` |
| outSample | output | DATA_W | Signed corrected sample, saturated |
| dcEstimate | output | DATA_W | Signed integer part of the DC estimate |

## Verification
The properties assume that `inSample` is a meaningful signed value only in cycles with `inValid` high. They also assume that reset is held for at least one edge before samples arrive. The stimulus drives inputs only on the falling edge, and it never raises `inValid` during reset. The stimulus uses long runs at both range extremes to move the estimate far enough from zero to force clamping in each direction. It also feeds the current integer estimate back as the input, which exercises the no-change case.

// File: rtl/dcTrackPkg.sv
package dcTrackPkg;
  // Strobes from control to datapath for one clock cycle.
  typedef struct packed {
    logic stepUp;    // move estimate up one fractional unit
    logic stepDown;  // move estimate down one fractional unit
    logic capture;   // register the corrected sample
  } trackCtrl_t;
endpackage

// File: rtl/dcTrackCtrl.sv
module dcTrackCtrl
  import dcTrackPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       inAbove,
  input  logic       inBelow,
  output trackCtrl_t ctrl,
  output logic       outValid
);
  always_comb begin
    ctrl.capture  = inValid;
    ctrl.stepUp   = inValid & inAbove;
    ctrl.stepDown = inValid & inBelow;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end
endmodule

// File: rtl/dcTrackPath.sv
module dcTrackPath
  import dcTrackPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  trackCtrl_t               ctrl,
  input  logic signed [DATA_W-1:0] inSample,
  output logic                     inAbove,
  output logic                     inBelow,
  output logic signed [DATA_W-1:0] outSample,
  output logic signed [DATA_W-1:0] dcEstimate
);
  localparam int ACC_W = DATA_W + FRAC_W;
  localparam logic signed [ACC_W-1:0] ONE_FRAC = ACC_W'(1);
  localparam logic signed [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [ACC_W-1:0]  estAcc;
  logic signed [DATA_W-1:0] estInt;
  logic signed [DATA_W:0]   rawDiff;
  logic signed [DATA_W-1:0] satDiff;

  // Upper bits of a two's complement fixed-point value give its floor.
  assign estInt     = estAcc[ACC_W-1:FRAC_W];
  assign dcEstimate = estInt;

  assign inAbove = inSample > estInt;
  assign inBelow = inSample < estInt;

  assign rawDiff = {inSample[DATA_W-1], inSample} - {estInt[DATA_W-1], estInt};

  always_comb begin
    if (rawDiff[DATA_W] != rawDiff[DATA_W-1])
      satDiff = rawDiff[DATA_W] ? NEG_LIM : POS_LIM;
    else
      satDiff = rawDiff[DATA_W-1:0];
  end

  // The estimate only ever moves toward an in-range input, so it stays in range.
  always_ff @(posedge clk) begin
    if (rst)                estAcc <= '0;
    else if (ctrl.stepUp)   estAcc <= estAcc + ONE_FRAC;
    else if (ctrl.stepDown) estAcc <= estAcc - ONE_FRAC;
  end

  always_ff @(posedge clk) begin
    if (rst)               outSample <= '0;
    else if (ctrl.capture) outSample <= satDiff;
  end
endmodule

// File: rtl/dcTracker.sv
module dcTracker
  import dcTrackPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inSample,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outSample,
  output logic signed [DATA_W-1:0] dcEstimate
);
  trackCtrl_t ctrl;
  logic       inAbove;
  logic       inBelow;

  dcTrackCtrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid),
    .inAbove(inAbove), .inBelow(inBelow),
    .ctrl(ctrl), .outValid(outValid)
  );

  dcTrackPath #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_path (
    .clk(clk), .rst(rst), .ctrl(ctrl), .inSample(inSample),
    .inAbove(inAbove), .inBelow(inBelow),
    .outSample(outSample), .dcEstimate(dcEstimate)
  );
endmodule

// File: rtl/dcTrackerChk.sv
module dcTrackerChk #(
  parameter int DATA_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     inValid,
  input logic signed [DATA_W-1:0] inSample,
  input logic                     outValid,
  input logic signed [DATA_W-1:0] outSample,
  input logic signed [DATA_W-1:0] dcEstimate
);
  localparam logic signed [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W+1:0] wideDiff;
  logic signed [DATA_W+1:0] estDelta;
  logic signed [DATA_W-1:0] prevEst;
  logic                     pastValid;
  logic                     overHigh;
  logic                     underLow;

  assign wideDiff = (DATA_W+2)'(inSample) - (DATA_W+2)'(dcEstimate);
  assign overHigh = wideDiff > (DATA_W+2)'(POS_LIM);
  assign underLow = wideDiff < (DATA_W+2)'(NEG_LIM);
  assign estDelta = (DATA_W+2)'(dcEstimate) - (DATA_W+2)'(prevEst);

  always_ff @(posedge clk) begin
    prevEst   <= dcEstimate;
    pastValid <= !rst;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (dcEstimate == '0 && !outValid && outSample == '0)); // R1
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid); // R2
  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid); // R2
  AST_EST_UP_DIR: assert property (@(posedge clk) disable iff (rst)
    (inValid && inSample > dcEstimate) |=> (dcEstimate >= $past(dcEstimate))); // R3
  AST_EST_SLEW: assert property (@(posedge clk) disable iff (rst)
    pastValid |-> (estDelta <= 1 && estDelta >= -1)); // R3
  AST_EST_DOWN_DIR: assert property (@(posedge clk) disable iff (rst)
    (inValid && inSample < dcEstimate) |=> (dcEstimate <= $past(dcEstimate))); // R4
  AST_EST_EQUAL: assert property (@(posedge clk) disable iff (rst)
    (inValid && inSample == dcEstimate) |=> $stable(dcEstimate)); // R5
  AST_EST_IDLE: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(dcEstimate)); // R6
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (inValid && overHigh) |=> (outSample == POS_LIM)); // R8
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
    (inValid && underLow) |=> (outSample == NEG_LIM)); // R9
endmodule

bind dcTracker dcTrackerChk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
  .outValid(outValid), .outSample(outSample), .dcEstimate(dcEstimate)
);

// File: tb/dcTracker_tb.sv
module dcTracker_tb;
  localparam int DW = 16;
  localparam int FW = 4;
  localparam int MAXV = 32767;
  localparam int MINV = -32768;

  typedef struct {
    int    expOut;
    int    expEst;
    string tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic signed [DW-1:0] inSample = '0;
  logic outValid;
  logic signed [DW-1:0] outSample;
  logic signed [DW-1:0] dcEstimate;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int lastEst = 0;
  longint modelAcc = 0;
  bit done = 1'b0;
  expItem_t sbQueue[$];

  always #10 clk = ~clk;

  dcTracker #(.DATA_W(DW), .FRAC_W(FW)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
    .outValid(outValid), .outSample(outSample), .dcEstimate(dcEstimate)
  );

  function automatic int modelInt();
    return int'(modelAcc >>> FW);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input int x, input string tag);
    expItem_t it;
    int d;
    @(negedge clk);
    inValid  = 1'b1;
    inSample = DW'(x);
    d = x - modelInt();
    if (d > MAXV) d = MAXV;
    if (d < MINV) d = MINV;
    it.expOut = d;
    if (x > modelInt()) modelAcc++;
    else if (x < modelInt()) modelAcc--;
    it.expEst = modelInt();
    it.tag = tag;
    sbQueue.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      inSample = 16'h5a5a;
    end
  endtask

  // Monitor: compares results against the scoreboard queue.
  initial begin
    expItem_t it;
    @(negedge rst);
    forever begin
      @(posedge clk);
      #2;
      if (outValid) begin
        if (sbQueue.size() == 0) begin
          check(1'b0, "R2", "unexpected outValid", 1, 0);
        end else begin
          it = sbQueue.pop_front();
          check(int'(outSample) == it.expOut, it.tag, "outSample", int'(outSample), it.expOut);
          check(int'(dcEstimate) == it.expEst, it.tag, "dcEstimate", int'(dcEstimate), it.expEst);
          lastEst = it.expEst;
        end
      end else begin
        // R6: with no sample the estimate stays put
        check(int'(dcEstimate) == lastEst, "R6", "idle dcEstimate", int'(dcEstimate), lastEst);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int r;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check(dcEstimate == '0, "R1", "reset dcEstimate", int'(dcEstimate), 0);
    check(outValid == 1'b0, "R1", "reset outValid", int'(outValid), 0);
    check(outSample == '0, "R1", "reset outSample", int'(outSample), 0);
    @(negedge clk);
    rst = 1'b0;

    // R3: input above estimate, estimate climbs slowly
    for (int i = 0; i < 40; i++) drive(100, "R3");
    // R6 with gaps between samples
    for (int i = 0; i < 6; i++) begin drive(100, "R3"); idle(3); end
    // R4: input below estimate
    for (int i = 0; i < 80; i++) drive(-50, "R4");
    idle(2);
    // R5: input equal to the current integer estimate
    for (int i = 0; i < 8; i++) drive(modelInt(), "R5");
    idle(2);
    // R7: mixed values
    for (int i = 0; i < 200; i++) begin
      r = int'($urandom_range(4000)) - 2000;
      drive(r, "R7");
      if (i % 17 == 0) idle(1);
    end
    // R10: constant input settles to zero output
    for (int i = 0; i < 40000; i++) begin
      if (modelInt() == 7) break;
      drive(7, "R7");
    end
    for (int i = 0; i < 5; i++) drive(7, "R10");
    idle(2);
    // R8: pull estimate negative, then a full-scale positive sample
    for (int i = 0; i < 1800; i++) drive(MINV, "R4");
    drive(MAXV, "R8");
    drive(MAXV, "R8");
    // R9: pull estimate positive, then a full-scale negative sample
    for (int i = 0; i < 3800; i++) drive(MAXV, "R3");
    drive(MINV, "R9");
    drive(MINV, "R9");
    idle(4);

    if (sbQueue.size() != 0)
      check(1'b0, "R2", "results missing", 0, sbQueue.size());
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule